// File: doc/BRIEF.md
# Synchronous Burst-Write Host Port

This block is the slave end of a synchronous host bus with a separate address bus. It takes 16-bit sequential burst writes from a host processor. All inputs are sampled on the host clock. A burst opens with a one-cycle low pulse on the strobe while select is low. The address present at that edge becomes the start address. From then on the block takes one data word at every clock edge at which the transfer is not held. Each word it takes leaves on an internal write port as a one-cycle write enable, together with the address and the data. The address then advances by one word. The host marks the final word by driving the last-word flag low alongside it.

Flow control is one-directional. The internal write port has no ready and must absorb one write per cycle. Back-pressure reaches the host through two active-low outputs, `rdy_n` and `stop_n`. `rdy_n` is low while a burst is open. `stop_n` follows the fullness of an internal command FIFO, one cycle late. The host treats a word as taken at a rising edge only if it saw `rdy_n` low and `stop_n` high before that edge, and it keeps the same word on the bus until then. A burst ends when its last word is taken or when the host raises select. A new burst needs select to have been high at least once since the previous one ended.

Top module: `bwr_host_port`

## Requirements
- R1: In idle, a clock edge that samples `sel_n`=0, `strb_n`=0 and `byte_en`=2'b11 opens a burst at the address on `addr`, and `rdy_n` is low in the following cycle. The first word is the one sampled at the next edge at which the transfer is not held.
- R2: The block takes a word at each edge that samples all of the following: the burst is open, `sel_n`=0, `stop_n`=1 and `byte_en`=2'b11. In the cycle after that edge, `wr_en` is 1 for exactly one cycle, with `wr_data` equal to the word taken. `wr_addr` equals the start address plus the number of words taken earlier in the burst, modulo 2^ADDR_W.
- R3: The word taken at an edge that samples `last_n`=0 is the final word of the burst, and `rdy_n` is high in the following cycle.
- R4: After a burst ends, strobes are ignored until an edge samples `sel_n`=1. A strobe while select stays low leaves `rdy_n` high and writes nothing.
- R5: An edge that samples `sel_n`=1 during a burst aborts it. No word is taken at that edge, `rdy_n` is high in the next cycle and the block returns to idle.
- R6: A strobe sampled with `byte_en` other than 2'b11 opens no burst. `rdy_n` stays high and no write happens until select has been released.
- R7: `stop_n` equals the inverse of `fifo_full` sampled at the previous edge, so it is low exactly while the FIFO was full.
- R8: An edge during a burst that samples `stop_n`=0, or `byte_en` other than 2'b11, is a wait cycle. No word is taken and the address does not advance.
- R9: Reset is synchronous and active low. After an edge with `rst_n`=0, the block is idle with `rdy_n`=1, `stop_n`=1 and `wr_en`=0, whatever `fifo_full` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Select, active low, held for the whole burst |
| strb_n | input | 1 | Burst-start strobe, active low, one cycle |
| addr | input | ADDR_W | Word address, sampled at the strobe |
| data | input | DATA_W | Write data from the host |
| last_n | input | 1 | Final-word flag, active low |
| byte_en | input | BE_W | Byte enables, all ones for a 16-bit access |
| fifo_full | input | 1 | Internal command FIFO is full |
| rdy_n | output | 1 | Data ready, active low |
| stop_n | output | 1 | Stop request, active low |
| wr_en | output | 1 | Internal write enable, one cycle per word |
| wr_addr | output | ADDR_W | Internal write address |
| wr_data | output | DATA_W | Internal write data |

## Verification
The hardest case to reach from the ports is a wait cycle that falls on the final word of a burst. At that edge `last_n` is low but the word must not be taken, so the burst has to stay open and the address has to stay where it is. A word must also not be written twice. Random bursts of up to eight words reach this case by raising `fifo_full` and corrupting `byte_en` with fixed probabilities on every cycle, so that stalls land on first, middle and last words alike. Directed sequences then add the early release of select, a strobe while select is still held after a completed burst, and a strobe with wrong byte enables.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_BURST   = 2'd1,
    S_RELEASE = 2'd2
  } bwr_state_e;
endpackage

// File: rtl/bwr_ctrl.sv
module bwr_ctrl
  import bwr_pkg::*;
#(
  parameter int BE_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic            strb_n,
  input  logic            last_n,
  input  logic [BE_W-1:0] be,
  input  logic            stop_n,
  output logic            rdy_n,
  output logic            start,
  output logic            take
);
  bwr_state_e st;
  logic       be_full;

  assign be_full = &be;
  assign start   = (st == S_IDLE) && !sel_n && !strb_n && be_full;
  assign take    = (st == S_BURST) && !sel_n && stop_n && be_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      rdy_n <= 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          if (!sel_n && !strb_n) begin
            st    <= be_full ? S_BURST : S_RELEASE;
            rdy_n <= !be_full;
          end
        end
        S_BURST: begin
          if (sel_n) begin
            st    <= S_IDLE;
            rdy_n <= 1'b1;
          end else if (take && !last_n) begin
            st    <= S_RELEASE;
            rdy_n <= 1'b1;
          end
        end
        S_RELEASE: begin
          if (sel_n) st <= S_IDLE;
        end
        default: begin
          st    <= S_IDLE;
          rdy_n <= 1'b1;
        end
      endcase
    end
  end

  AST_TAKE_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !rdy_n); // R2
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !last_n) |=> rdy_n); // R3
  AST_SEL_HIGH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> rdy_n); // R5
endmodule

// File: rtl/bwr_addr_gen.sv
module bwr_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] cur
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= load_addr;
    else if (step) cur <= cur + ONE;
  end
endmodule

// File: rtl/bwr_wr_stage.sv
module bwr_wr_stage #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= take;
      if (take) begin
        wr_addr <= addr_in;
        wr_data <= data_in;
      end
    end
  end
endmodule

// File: rtl/bwr_host_port.sv
module bwr_host_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              strb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              last_n,
  input  logic [BE_W-1:0]   byte_en,
  input  logic              fifo_full,
  output logic              rdy_n,
  output logic              stop_n,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              start;
  logic              take;
  logic [ADDR_W-1:0] cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) stop_n <= 1'b1;
    else        stop_n <= !fifo_full;
  end

  bwr_ctrl #(.BE_W(BE_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_n  (sel_n),
    .strb_n (strb_n),
    .last_n (last_n),
    .be     (byte_en),
    .stop_n (stop_n),
    .rdy_n  (rdy_n),
    .start  (start),
    .take   (take)
  );

  bwr_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_addr (addr),
    .step      (take),
    .cur       (cur_addr)
  );

  bwr_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .addr_in (cur_addr),
    .data_in (data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |=> !wr_en); // R8
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ONE)); // R2
  AST_BE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(byte_en) == {BE_W{1'b1}})); // R6
  AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(sel_n)); // R5
endmodule

// File: tb/test_bwr_host_port.sv
module test_bwr_host_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, strb_n = 1'b1, last_n = 1'b1, fifo_full = 1'b0;
  logic [15:0] addr = '0, data = '0;
  logic [1:0]  byte_en = 2'b11;
  logic        rdy_n, stop_n, wr_en;
  logic [15:0] wr_addr, wr_data;

  int checks = 0, fails = 0;
  logic [31:0] expq[$];

  always #2.5 clk = ~clk;

  bwr_host_port i_bwr_host_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strb_n(strb_n), .addr(addr),
    .data(data), .last_n(last_n), .byte_en(byte_en), .fifo_full(fifo_full),
    .rdy_n(rdy_n), .stop_n(stop_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [31:0] pack(input logic [15:0] a, input logic [15:0] d);
    return {a, d};
  endfunction

  // write monitor: R2 order, address and data against the reference queue
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2 unexpected write", pack(wr_addr, wr_data), 32'h0);
      end else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(pack(wr_addr, wr_data) == e, "R2 write", pack(wr_addr, wr_data), e);
      end
    end
  end

  task automatic burst(input logic [15:0] a, input int n, input int stall_pct,
                       input int be_pct, input int abort_at, input bit hold_sel);
    int i = 0;
    sel_n = 1'b0; strb_n = 1'b0; addr = a; byte_en = 2'b11; fifo_full = 1'b0;
    tick();
    strb_n = 1'b1; addr = 16'($urandom);
    chk(rdy_n == 1'b0, "R1 rdy_n low after strobe", 32'(rdy_n), 32'h0);
    while (i < n) begin
      bit acc, bad, exp_stop;
      if (abort_at >= 0 && i == abort_at) begin
        sel_n = 1'b1; fifo_full = 1'b0; byte_en = 2'b11;
        tick();
        chk(rdy_n == 1'b1, "R5 rdy_n high after abort", 32'(rdy_n), 32'h1);
        tick(); tick();
        chk(expq.size() == 0, "R5 no write after abort", 32'(expq.size()), 32'h0);
        return;
      end
      data = 16'($urandom);
      last_n = (i == n - 1) ? 1'b0 : 1'b1;
      bad = (($urandom % 100) < 32'(be_pct));
      byte_en = bad ? 2'b10 : 2'b11;
      acc = (stop_n == 1'b1) && !bad;
      if (acc) expq.push_back(pack(16'(a + 16'(i)), data));
      fifo_full = (($urandom % 100) < 32'(stall_pct));
      exp_stop = !fifo_full;
      tick();
      chk(stop_n == exp_stop, "R7 stop_n follows fifo_full", 32'(stop_n), 32'(exp_stop));
      if (acc) i++;
      if (i < n)
        chk(rdy_n == 1'b0, "R8 burst stays open across waits", 32'(rdy_n), 32'h0);
    end
    chk(rdy_n == 1'b1, "R3 rdy_n high after last word", 32'(rdy_n), 32'h1);
    last_n = 1'b1; fifo_full = 1'b0; byte_en = 2'b11;
    if (!hold_sel) begin
      sel_n = 1'b1;
      tick();
    end
    tick();
    chk(expq.size() == 0, "R2 all words written", 32'(expq.size()), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1553));
    fifo_full = 1'b1;
    @(negedge clk); tick(); tick();
    chk(rdy_n == 1'b1, "R9 reset rdy_n", 32'(rdy_n), 32'h1);
    chk(stop_n == 1'b1, "R9 reset stop_n", 32'(stop_n), 32'h1);
    chk(wr_en == 1'b0, "R9 reset wr_en", 32'(wr_en), 32'h0);
    fifo_full = 1'b0; rst_n = 1'b1;
    tick();

    // directed lengths 1, 2, 8; address wrap across the top
    burst(16'h0100, 1, 0, 0, -1, 1'b0);
    burst(16'h0200, 2, 0, 0, -1, 1'b0);
    burst(16'hFFFC, 8, 0, 0, -1, 1'b0);
    burst(16'h0300, 8, 50, 0, -1, 1'b0);

    // R8: corrupted byte enables mid-burst act as waits
    burst(16'h0400, 8, 0, 40, -1, 1'b0);

    // R5: early select release after three words
    burst(16'h0500, 8, 20, 0, 3, 1'b0);

    // R4: strobe again while select still held after completion
    burst(16'h0600, 2, 0, 0, -1, 1'b1);
    strb_n = 1'b0; addr = 16'h0700;
    tick();
    strb_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      data = 16'($urandom); last_n = k[0];
      tick();
      chk(rdy_n == 1'b1, "R4 strobe ignored while select held", 32'(rdy_n), 32'h1);
    end
    last_n = 1'b1; sel_n = 1'b1;
    tick();

    // R6: strobe with wrong byte enables
    sel_n = 1'b0; strb_n = 1'b0; byte_en = 2'b01; addr = 16'h0800;
    tick();
    strb_n = 1'b1; byte_en = 2'b11;
    for (int k = 0; k < 4; k++) begin
      data = 16'($urandom); last_n = (k == 3) ? 1'b0 : 1'b1;
      tick();
      chk(rdy_n == 1'b1, "R6 burst refused on byte enables", 32'(rdy_n), 32'h1);
    end
    last_n = 1'b1; sel_n = 1'b1;
    tick(); tick();
    chk(expq.size() == 0, "R6 no writes", 32'(expq.size()), 32'h0);

    // R7: stop_n low exactly while FIFO full
    fifo_full = 1'b1;
    tick();
    chk(stop_n == 1'b0, "R7 stop_n low when full", 32'(stop_n), 32'h0);
    fifo_full = 1'b0;
    tick();
    chk(stop_n == 1'b1, "R7 stop_n high when not full", 32'(stop_n), 32'h1);

    // random bursts
    for (int b = 0; b < 40; b++) begin
      int len;
      int ab;
      len = 1 + int'($urandom % 8);
      ab = (($urandom % 8) == 0) ? int'($urandom % 32'(len)) : -1;
      burst(16'($urandom), len, 30, 10, ab, 1'b0);
      repeat ($urandom % 3) tick();
    end

    tick(); tick();
    chk(expq.size() == 0, "R2 reference queue drained", 32'(expq.size()), 32'h0);
    summary();
  end
endmodule